// File: doc/BRIEF.md
# SMBus Block-Write Configuration Slave

This block is a write-only two-wire serial slave that fills a small bank of byte-wide configuration registers for a clock generator. It watches the clock and data lines and synchronizes both to the system clock. It recognizes start and stop conditions and answers to a 7-bit address that three strap inputs select. It accepts one kind of transaction, a block write: an address byte, an all-zero command byte, a byte count and then the data bytes. The data bytes go into the register bank in order, starting at register 0.

Every register comes up at a fixed default, so a board that never talks to the block still gets a working configuration. All registers are visible as one flat parallel output. Register 0 also drives two gated outputs: a spread-enable and a 3-bit frequency select. Both are forced off while the override bit (bit 0) of register 0 is set. The slave pulls the data line low through an open-drain enable to acknowledge a byte. It never drives data back, because reads are not supported.

Top module: `cfg_smb_slave`

## Requirements
- R1: After reset, register 0 reads 0xA0 (bit 7 = 1, bit 6 = 0, bit 5 = 1, bits 4:2 = 0). Registers 1..3 read 0x00, 0x3C and 0x0F. `regs_o[8*k+7:8*k]` carries register k, and `sda_oe_o` is 0.
- R2: The 8-bit write address, indexed by `strap_i`, is 0→0xDE, 1→0xDC, 2→0xDA, 3→0xD8, 4→0xD6, 5→0xD4, 6→0xD0, 7→0xD2. The 7-bit slave address is bits 7:1 of it. A matching address byte with bit 0 = 0 is acknowledged.
- R3: An address byte that matches but has bit 0 = 1 (a read) is not acknowledged. No register changes until the next start.
- R4: A command byte other than 0x00 is not acknowledged. The rest of the transfer is ignored until the next start.
- R5: The byte-count byte is always acknowledged. Data bytes arrive MSB first, are acknowledged, and are written to register 0, 1, 2 and so on in arrival order.
- R6: A data byte whose position is at or beyond the byte count, or at or beyond the number of registers, is not acknowledged and writes nothing.
- R7: A stop after any whole byte ends the transfer. The data bytes already acknowledged keep their values.
- R8: A repeated start at any point aborts the current transfer and begins a new address phase. Registers already written keep their values, and a partly shifted byte writes nothing.
- R9: `sda_oe_o` changes only while the synchronized clock line is low. It is asserted only inside an accepted transfer.
- R10: `spread_eff_o` equals register 0 bit 6, and `fsel_eff_o` equals register 0 bits 4:2, while register 0 bit 0 is 0. Both are 0 while that bit is 1.
- R11: An address byte that does not match the strap-selected address is not acknowledged, and the transfer is ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Address select straps |
| sda_oe_o | output | 1 | Open-drain pull-low enable for the data line |
| regs_o | output | 8*NUM_REGS | All registers, register k in byte k |
| spread_eff_o | output | 1 | Gated spread enable |
| fsel_eff_o | output | 3 | Gated frequency select |

## Verification
The in-RTL assertions check on every cycle that the acknowledge drive moves only during clock-low and only inside an accepted transfer. They also check that registers change only in the data phase, that the write index stays within the bank, that a read bit or a nonzero command pushes the slave into the ignore state, and that the override bit gates the effective outputs. Only the bench's transactions can show the address map for each strap setting and the ordering of bytes into the bank. The same holds for the count and bank-size limits, for early stops and for the abort on a repeated start. The bench judges all of these by the acknowledges it sees and the register values left behind.

// File: rtl/cfg_smb_slave.sv
module cfg_smb_slave #(
  parameter int NUM_REGS = 4,
  parameter logic [8*NUM_REGS-1:0] DEFAULTS = 32'h0F3C00A0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [2:0]            strap_i,
  output logic                  sda_oe_o,
  output logic [8*NUM_REGS-1:0] regs_o,
  output logic                  spread_eff_o,
  output logic [2:0]            fsel_eff_o
);
  localparam int IW = $clog2(NUM_REGS + 1);
  localparam int AW = $clog2(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic [7:0] sh, cnt;
  logic [3:0] bitc;
  logic       ackph, do_ack;
  logic [IW-1:0] idx;
  logic [6:0] my_addr;
  st_t        st;
  logic [7:0] rf [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire byte_end = scl_fall & ~ackph & (bitc == 4'd8);
  wire in_xfer  = (st != S_IDLE) && (st != S_SKIP);
  wire room     = (int'(idx) < int'(cnt)) && (int'(idx) < NUM_REGS);

  always_comb
    case (strap_i)
      3'd0: my_addr = 7'h6F;
      3'd1: my_addr = 7'h6E;
      3'd2: my_addr = 7'h6D;
      3'd3: my_addr = 7'h6C;
      3'd4: my_addr = 7'h6B;
      3'd5: my_addr = 7'h6A;
      3'd6: my_addr = 7'h68;
      default: my_addr = 7'h69;
    endcase

  always_comb
    case (st)
      S_ADDR:  do_ack = (sh == {my_addr, 1'b0});
      S_CMD:   do_ack = (sh == 8'h00);
      S_CNT:   do_ack = 1'b1;
      S_DATA:  do_ack = room;
      default: do_ack = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; bitc <= '0; ackph <= 1'b0;
      idx <= '0; sda_oe_o <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= DEFAULTS[8*i +: 8];
    end else if (start_c) begin
      st <= S_ADDR; bitc <= '0; ackph <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; bitc <= '0; ackph <= 1'b0; sda_oe_o <= 1'b0;
    end else if (in_xfer) begin
      if (scl_rise && !ackph && bitc != 4'd8) begin
        sh   <= {sh[6:0], sda_s};
        bitc <= bitc + 4'd1;
      end
      if (byte_end) begin
        ackph    <= 1'b1;
        sda_oe_o <= do_ack;
        case (st)
          S_ADDR: st <= do_ack ? S_CMD : S_SKIP;
          S_CMD:  st <= do_ack ? S_CNT : S_SKIP;
          S_CNT: begin cnt <= sh; idx <= '0; st <= S_DATA; end
          S_DATA: if (do_ack) begin
            rf[idx[AW-1:0]] <= sh;
            idx <= idx + 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && ackph) begin
        ackph <= 1'b0; sda_oe_o <= 1'b0; bitc <= '0;
      end
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_o[8*g +: 8] = rf[g];
  end

  assign spread_eff_o = rf[0][6] & ~rf[0][0];
  assign fsel_eff_o   = rf[0][0] ? 3'b000 : rf[0][4:2];

  a_r9_oe_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_s));
  a_r9_oe_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (st != S_IDLE && st != S_SKIP));
  a_r5_write_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> ($past(st) == S_DATA));
  a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) <= NUM_REGS);
  a_r3_read_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !start_c && !stop_c && st == S_ADDR && sh[0]) |=> (st == S_SKIP && !sda_oe_o));
  a_r4_cmd_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !start_c && !stop_c && st == S_CMD && sh != 8'h00) |=> (st == S_SKIP));
  a_r10_override_gates: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[0] |-> (!spread_eff_o && fsel_eff_o == 3'b000));
endmodule

// File: tb/test_cfg_smb_slave.sv
module test_cfg_smb_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  typedef struct packed {
    logic [2:0]  strap;
    logic [7:0]  addr;
    logic [7:0]  cmd;
    logic [7:0]  cnt;
    logic [2:0]  nsend;
    logic [39:0] data;
    logic [31:0] exp;
    logic [3:0]  nack;
  } vec_t;

  // R2 R3 R4 R5 R6 R7 R11: registers accumulate from row to row
  localparam vec_t VECS [8] = '{
    '{3'd0, 8'hDE, 8'h00, 8'h02, 3'd2, 40'h0000002211, 32'h0F3C2211, 4'd5},
    '{3'd3, 8'hD8, 8'h00, 8'h04, 3'd4, 40'h0088776655, 32'h88776655, 4'd7},
    '{3'd6, 8'hD0, 8'h00, 8'h01, 3'd3, 40'h0000BBAA01, 32'h88776601, 4'd4},
    '{3'd7, 8'hD2, 8'h05, 8'h02, 3'd1, 40'h00000000EE, 32'h88776601, 4'd1},
    '{3'd5, 8'hD6, 8'h00, 8'h02, 3'd1, 40'h00000000EE, 32'h88776601, 4'd0},
    '{3'd2, 8'hDB, 8'h00, 8'h02, 3'd1, 40'h00000000EE, 32'h88776601, 4'd0},
    '{3'd4, 8'hD6, 8'h00, 8'h08, 3'd5, 40'h5040302010, 32'h40302010, 4'd7},
    '{3'd1, 8'hDC, 8'h00, 8'h03, 3'd1, 40'h00000000C4, 32'h403020C4, 4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'd0;
  wire        sda_oe;
  wire [31:0] regs;
  wire        sp;
  wire [2:0]  fs;
  wire        sda_bus = m_sda & ~sda_oe;

  cfg_smb_slave i_cfg_smb_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .regs_o(regs), .spread_eff_o(sp), .fsel_eff_o(fs));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errs = 0, checks = 0, acks = 0, oe_bad = 0;
  logic oe_q = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (sda_oe !== oe_q && m_scl) oe_bad++;
    oe_q = sda_oe;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic go_start;
    m_sda = 1'b1; hold(Q); m_scl = 1'b1; hold(Q); m_sda = 1'b0; hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic go_stop;
    m_sda = 1'b0; hold(Q); m_scl = 1'b1; hold(Q); m_sda = 1'b1; hold(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hold(Q); m_scl = 1'b1; hold(2*Q); m_scl = 1'b0; hold(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    send_bits(b, 8);
    m_sda = 1'b1; hold(Q); m_scl = 1'b1; hold(Q);
    if (sda_bus == 1'b0) acks++;
    hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    hold(3);
    chk("R1 reset registers", regs, 32'h0F3C00A0);
    chk("R1 reset ack drive", {31'b0, sda_oe}, 32'h0);
    chk("R10 reset effective outputs", {28'b0, sp, fs}, 32'h0);
    rst_n = 1'b1;
    hold(4);

    for (int v = 0; v < 8; v++) begin
      strap = VECS[v].strap;
      acks = 0;
      hold(Q);
      go_start();
      send_byte(VECS[v].addr);
      send_byte(VECS[v].cmd);
      send_byte(VECS[v].cnt);
      for (int k = 0; k < int'(VECS[v].nsend); k++) send_byte(VECS[v].data[8*k +: 8]);
      go_stop();
      hold(Q);
      chk($sformatf("R2 R3 R4 R5 R6 R7 R11 row %0d registers", v), regs, VECS[v].exp);
      chk($sformatf("R2 R3 R4 R5 R6 R11 row %0d ack count", v), acks, {28'b0, VECS[v].nack});
    end

    // R10: override clear, then set
    strap = 3'd0;
    hold(Q);
    go_start(); send_byte(8'hDE); send_byte(8'h00); send_byte(8'h01); send_byte(8'h5C); go_stop();
    hold(Q);
    chk("R10 effective outputs pass through", {28'b0, sp, fs}, 32'h0000000F);
    go_start(); send_byte(8'hDE); send_byte(8'h00); send_byte(8'h01); send_byte(8'h5D); go_stop();
    hold(Q);
    chk("R10 effective outputs gated", {28'b0, sp, fs}, 32'h0);
    chk("R10 raw register kept", regs, 32'h4030205D);

    // R8: repeated start in the middle of the second data byte
    acks = 0;
    go_start(); send_byte(8'hDE); send_byte(8'h00); send_byte(8'h04); send_byte(8'hE1);
    send_bits(8'hFF, 4);
    go_start(); send_byte(8'hDE); send_byte(8'h00); send_byte(8'h00); go_stop();
    hold(Q);
    chk("R8 registers after repeated start", regs, 32'h403020E1);
    chk("R8 ack count across repeated start", acks, 32'd7);

    chk("R9 ack drive changed while clock high", oe_bad, 32'd0);
    done = 1'b1;
    report();
  end
endmodule